// File: doc/BRIEF.md
# Burst Beat Address Generator

This block sits on the requesting side of a burst-capable bus. It produces the address of every beat of a burst. A one-cycle start pulse loads the first address, a beat-size code and a burst-type code. From the next cycle on, the block presents one address per beat. It moves to the next beat only when the downstream ready signal accepts the current one.

Incrementing bursts add the beat size on every accepted beat. The carry runs through the full address, so these bursts may run past any block boundary. Wrapping bursts stay inside one naturally aligned block of `L × s` bytes. Only the low `log2(L × s)` bits count upward. The carry out of those bits is dropped, and the upper bits keep the block's aligned base.

The block also marks the first beat as non-sequential and every later beat as sequential. It raises a final-beat flag for single transfers and fixed-length bursts. An undefined-length burst runs until the requester raises a stop input on an accepted beat. The requester must align the start address to the beat size.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset `active_o`, `seq_o` and `last_o` are 0 and `addr_o` is all zeros.
- R2: A `start_i` pulse while idle makes `active_o` 1 on the next cycle, with `addr_o` equal to `start_addr_i`.
- R3: In an incrementing burst, each accepted beat adds s = 2^`size_i` bytes to the address. The carry spreads into every upper bit, so beat n sits at start + n·s modulo 2^ADDR_W.
- R4: Wrapping bursts use `burst_i` codes 010, 100 and 110 for L = 4, 8 and 16 beats. With B = L·s, beat n sits at (start & ~(B−1)) | ((start + n·s) & (B−1)). Example: 4-byte words of a 4-beat wrap from 0x1008 give 0x1008, 0x100C, 0x1000, 0x1004.
- R5: Code 000 is a single beat. Codes 011, 101 and 111 are incrementing bursts of 4, 8 and 16 beats. A fixed-length burst issues exactly L beats, with `last_o` high on the final beat only. Once that beat is accepted, `active_o` is 0 on the next cycle.
- R6: Code 001 is an undefined-length incrementing burst. It never raises `last_o` and runs past 16 beats. It ends when a beat is accepted with `stop_i` high. `stop_i` has no effect on fixed-length bursts.
- R7: While `ready_i` is low during a burst, `addr_o`, `seq_o`, `last_o` and `active_o` hold their values.
- R8: `seq_o` is 0 on the first beat of a burst and 1 on every later beat.
- R9: A `start_i` pulse while a burst is active is ignored. The running burst continues with its own addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load a new burst when idle |
| start_addr_i | input | ADDR_W | First beat address, aligned to the beat size |
| size_i | input | 3 | Beat size code, s = 2^code bytes |
| burst_i | input | 3 | Burst type code |
| ready_i | input | 1 | Downstream accepts the current beat |
| stop_i | input | 1 | Ends an undefined-length burst on the accepted beat |
| active_o | output | 1 | An address is being presented |
| addr_o | output | ADDR_W | Current beat address |
| seq_o | output | 1 | 0 on the first beat, 1 on later beats |
| last_o | output | 1 | Final beat of a single or fixed-length burst |

## Verification
The bench builds the block with a 16-bit address. This lets start addresses near 0xFFFF show incrementing bursts wrapping through the top of the address space. The same width holds the largest wrap block, 16 beats of 128 bytes, which is 2048 bytes.

The bench sweeps all eight burst codes against all eight size codes from several start points, including a few mid-block starts. This reaches every wrap boundary from 4 bytes up to 2048 bytes. Runs with stall cycles, stray start pulses and stray stop pulses are mixed into the sweep.

// File: rtl/bag_pkg.sv
package bag_pkg;

   localparam int LEN_LOG_MAX = 4;
   localparam int LEN_W       = LEN_LOG_MAX;
   localparam int SIZE_W      = 3;
   localparam int SIZE_LOG_MAX = (1 << SIZE_W) - 1;
   localparam int OFF_W       = LEN_LOG_MAX + SIZE_LOG_MAX;

   typedef enum logic [2:0] {
      BT_SINGLE = 3'b000,
      BT_UNDEF  = 3'b001,
      BT_WRAP4  = 3'b010,
      BT_INCR4  = 3'b011,
      BT_WRAP8  = 3'b100,
      BT_INCR8  = 3'b101,
      BT_WRAP16 = 3'b110,
      BT_INCR16 = 3'b111
   } burst_code_e;

   typedef struct packed {
      logic             wrap;
      logic             fixed;
      logic [LEN_W-1:0] len_m1;
      logic [2:0]       len_log;
   } burst_cfg_t;

endpackage

// File: rtl/bag_decode.sv
module bag_decode
   import bag_pkg::*;
(
   input  logic [2:0] code_i,
   output burst_cfg_t cfg_o
);

   always_comb begin
      cfg_o = '0;
      case (burst_code_e'(code_i))
         BT_SINGLE: begin
            cfg_o.fixed   = 1'b1;
            cfg_o.len_m1  = LEN_W'(0);
            cfg_o.len_log = 3'd0;
         end
         BT_UNDEF: begin
            cfg_o.fixed   = 1'b0;
            cfg_o.len_m1  = '1;
            cfg_o.len_log = 3'd0;
         end
         BT_WRAP4, BT_INCR4: begin
            cfg_o.fixed   = 1'b1;
            cfg_o.wrap    = (code_i == BT_WRAP4);
            cfg_o.len_m1  = LEN_W'(3);
            cfg_o.len_log = 3'd2;
         end
         BT_WRAP8, BT_INCR8: begin
            cfg_o.fixed   = 1'b1;
            cfg_o.wrap    = (code_i == BT_WRAP8);
            cfg_o.len_m1  = LEN_W'(7);
            cfg_o.len_log = 3'd3;
         end
         BT_WRAP16, BT_INCR16: begin
            cfg_o.fixed   = 1'b1;
            cfg_o.wrap    = (code_i == BT_WRAP16);
            cfg_o.len_m1  = LEN_W'(15);
            cfg_o.len_log = 3'd4;
         end
         default: cfg_o = '0;
      endcase
   end

endmodule

// File: rtl/bag_next_addr.sv
module bag_next_addr
   import bag_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] cur_i,
   input  logic [SIZE_W-1:0] size_i,
   input  logic [2:0]        len_log_i,
   input  logic              wrap_i,
   output logic [ADDR_W-1:0] nxt_o
);

   localparam int SH_W = 4;

   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] sum;
   logic [SH_W-1:0]   blk_log;
   logic [ADDR_W-1:0] off_mask;

   assign step     = ADDR_W'(1) << size_i;
   assign sum      = cur_i + step;
   assign blk_log  = {1'b0, len_log_i} + {1'b0, size_i};
   assign off_mask = (ADDR_W'(1) << blk_log) - ADDR_W'(1);

   // Per bit: offset bits take the sum, block bits keep the base when wrapping.
   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      assign nxt_o[i] = (wrap_i && !off_mask[i]) ? cur_i[i] : sum[i];
   end

endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr
   import bag_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             adv_i,
   input  logic             active_i,
   input  logic             fixed_i,
   input  logic [LEN_W-1:0] len_m1_i,
   output logic             is_last_o
);

   logic [LEN_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (adv_i && fixed_i) begin
         cnt_q <= cnt_q + LEN_W'(1);
      end
   end

   assign is_last_o = fixed_i && (cnt_q == len_m1_i);

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && fixed_i) |-> (cnt_q <= len_m1_i)); // R5

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import bag_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic [2:0]        size_i,
   input  logic [2:0]        burst_i,
   input  logic              ready_i,
   input  logic              stop_i,
   output logic              active_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              seq_o,
   output logic              last_o
);

   if (ADDR_W < OFF_W + 1) begin : g_bad_width
      $error("burst_addr_gen: ADDR_W must exceed the widest wrap offset");
   end

   burst_cfg_t        dec_cfg;
   burst_cfg_t        cfg_q;
   logic [2:0]        size_q;
   logic              active_q;
   logic              seq_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_nxt;
   logic              is_last;
   logic              load;
   logic              accept;
   logic              finish;

   bag_decode u_dec (
      .code_i (burst_i),
      .cfg_o  (dec_cfg)
   );

   bag_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
      .cur_i     (addr_q),
      .size_i    (size_q),
      .len_log_i (cfg_q.len_log),
      .wrap_i    (cfg_q.wrap),
      .nxt_o     (addr_nxt)
   );

   assign load   = start_i && !active_q;
   assign accept = active_q && ready_i;
   assign finish = accept && ((cfg_q.fixed && is_last) || (!cfg_q.fixed && stop_i));

   bag_beat_ctr u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (load),
      .adv_i     (accept && !finish),
      .active_i  (active_q),
      .fixed_i   (cfg_q.fixed),
      .len_m1_i  (cfg_q.len_m1),
      .is_last_o (is_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         seq_q    <= 1'b0;
         addr_q   <= '0;
         size_q   <= '0;
         cfg_q    <= '0;
      end else if (load) begin
         active_q <= 1'b1;
         seq_q    <= 1'b0;
         addr_q   <= start_addr_i;
         size_q   <= size_i;
         cfg_q    <= dec_cfg;
      end else if (finish) begin
         active_q <= 1'b0;
         seq_q    <= 1'b0;
      end else if (accept) begin
         seq_q    <= 1'b1;
         addr_q   <= addr_nxt;
      end
   end

   assign active_o = active_q;
   assign addr_o   = addr_q;
   assign seq_o    = seq_q;
   assign last_o   = active_q && is_last;

   logic [ADDR_W-1:0] blk_mask;
   assign blk_mask = (ADDR_W'(1) << ({1'b0, cfg_q.len_log} + {1'b0, size_q})) - ADDR_W'(1);

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && !ready_i) |=> (active_o && $stable(addr_o) && $stable(seq_o) && $stable(last_o))); // R7

   AST_FIRST_NONSEQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_o) |-> !seq_o); // R8

   AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && ready_i && last_o) |=> !active_o); // R5

   AST_WRAP_BASE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && ready_i && !last_o && cfg_q.wrap)
      |=> ((addr_o & ~blk_mask) == ($past(addr_o) & ~blk_mask))); // R4

   AST_INCR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && ready_i && !last_o && !cfg_q.wrap && !(stop_i && !cfg_q.fixed))
      |=> (addr_o == $past(addr_o) + (ADDR_W'(1) << size_q))); // R3

   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && start_i && ready_i && !last_o && cfg_q.fixed) |=> (active_o && seq_o)); // R9

   AST_UNDEF_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && seq_o && !cfg_q.fixed) |-> !last_o); // R6

endmodule

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW-1:0] start_addr_i = '0;
   logic [2:0]    size_i = '0;
   logic [2:0]    burst_i = '0;
   logic          ready_i = 1'b0;
   logic          stop_i = 1'b0;
   logic          active_o;
   logic [AW-1:0] addr_o;
   logic          seq_o;
   logic          last_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW)) u0 (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .start_addr_i (start_addr_i),
      .size_i (size_i), .burst_i (burst_i), .ready_i (ready_i), .stop_i (stop_i),
      .active_o (active_o), .addr_o (addr_o), .seq_o (seq_o), .last_o (last_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int beats_of(input int code);
      case (code)
         0: return 1;
         1: return 20;
         2, 3: return 4;
         4, 5: return 8;
         default: return 16;
      endcase
   endfunction

   function automatic logic [AW-1:0] exp_addr(input int code, input int size,
                                              input logic [AW-1:0] st, input int n);
      int s    = 1 << size;
      int lin  = int'(st) + n * s;
      bit wrap = (code == 2) || (code == 4) || (code == 6);
      if (wrap) begin
         int blk  = beats_of(code) * s;
         int base = int'(st) & ~(blk - 1);
         return AW'(base | (lin & (blk - 1)));
      end
      return AW'(lin);
   endfunction

   task automatic run(input int code, input int size, input logic [AW-1:0] st0,
                      input bit stall, input bit poke);
      logic [AW-1:0] st;
      logic [AW-1:0] prev;
      int            beats = beats_of(code);
      bit            fixed = (code != 1);
      bit            wrap  = (code == 2) || (code == 4) || (code == 6);
      string         areq;
      st   = st0 & ~AW'((1 << size) - 1);
      areq = (code == 1) ? "R6" : (wrap ? "R4" : "R3");
      @(negedge clk);
      start_i = 1'b1; start_addr_i = st; size_i = 3'(size); burst_i = 3'(code);
      ready_i = 1'b0; stop_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0; start_addr_i = 16'hBEEF;
      chk(active_o == 1'b1, "R2 active", int'(active_o), 1);
      chk(addr_o == st, "R2 first addr", int'(addr_o), int'(st));
      for (int n = 0; n < beats; n++) begin
         if (stall && (n % 3 == 1)) begin
            ready_i = 1'b0;
            prev = addr_o;
            @(negedge clk);
            chk(addr_o == prev && active_o, "R7 stall hold", int'(addr_o), int'(prev));
         end
         ready_i = 1'b1;
         if (poke && n == 1) begin
            start_i = 1'b1; start_addr_i = 16'h5550;
         end
         if (fixed && n == 1) stop_i = 1'b1;
         if (!fixed) stop_i = (n == beats - 1);
         chk(addr_o == exp_addr(code, size, st, n), areq, int'(addr_o),
             int'(exp_addr(code, size, st, n)));
         if (poke && n == 2)
            chk(addr_o == exp_addr(code, size, st, n), "R9 start ignored", int'(addr_o),
                int'(exp_addr(code, size, st, n)));
         chk(seq_o == (n != 0), "R8 seq", int'(seq_o), int'(n != 0));
         if (fixed)
            chk(last_o == (n == beats - 1), "R5 last", int'(last_o), int'(n == beats - 1));
         else
            chk(last_o == 1'b0, "R6 no last", int'(last_o), 0);
         @(negedge clk);
         start_i = 1'b0; stop_i = 1'b0;
      end
      ready_i = 1'b0;
      chk(active_o == 1'b0, fixed ? "R5 ends" : "R6 ends", int'(active_o), 0);
   endtask

   initial begin
      logic [AW-1:0] starts [5];
      starts[0] = 16'h1008; starts[1] = 16'h2010; starts[2] = 16'h3038;
      starts[3] = 16'hFFE8; starts[4] = 16'h07F4;
      repeat (3) @(negedge clk);
      chk(active_o == 1'b0 && seq_o == 1'b0 && last_o == 1'b0, "R1 flags", int'({active_o, seq_o, last_o}), 0);
      chk(addr_o == '0, "R1 addr", int'(addr_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int code = 0; code < 8; code++)
         for (int size = 0; size < 8; size++)
            for (int k = 0; k < 5; k++)
               run(code, size, starts[k], ((code + size + k) % 2) == 1, (k % 2) == 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule